// File: doc/BRIEF.md
# Alert Escalation Phase Sequencer

This block collects alert requests from many sources, filters them through a per-alert enable mask and starts an escalation when any enabled alert is seen. Escalation moves through four ordered phases. Each phase drives its own request line toward a receiver and holds it for a programmable number of cycles. The first line is a non-maskable interrupt, the second asks for device secrets to be wiped, the third asks for the device to be moved to its permanent scrap state, and the fourth asks for a chip reset.

Software can inject any alert through a per-alert test strobe, and this behaves exactly like the source raising it. Software ends an escalation with a clear pulse. Each request line is paired with an acknowledge input. An acknowledge that rises while its request is low is a protocol violation, and it is flagged and held until the next clear.

When the reset phase begins, the block stores the set of alerts seen so far in a cause record. That record sits in a power-on reset domain, so it survives the chip reset that the block itself requests.

States: IDLE, NMI, WIPE, SCRAP, RESET, DONE. The transitions are as follows. IDLE→NMI on an enabled alert. NMI→WIPE, WIPE→SCRAP, SCRAP→RESET and RESET→DONE each occur when the phase's cycle count expires. Any state→IDLE on clear.

Top module: `esc_phase_seq`

## Requirements
- R1: After reset, all escalation requests and all error flags are low.
- R2: An alert request whose enable bit is 1 moves the sequencer to the NMI state, so esc_req_o = 4'b0001 in the cycle after the edge that samples the alert. An alert request whose enable bit is 0 has no effect.
- R3: A pulse on alert_test_i[k] with enable bit k set starts escalation and is recorded in the cause word, exactly as alert_req_i[k] would be.
- R4: Phases run in the order NMI (bit 0), WIPE (bit 1), SCRAP (bit 2), RESET (bit 3). esc_req_o is one-hot during a phase, and phase k lasts exactly phase_cyc_i[k] cycles. A length of 0 counts as 1.
- R5: After the RESET phase the sequencer enters DONE with all requests low. Alerts in DONE have no effect until a clear.
- R6: clr_i returns the sequencer to IDLE, so all requests are low in the next cycle. clr_i takes priority over a simultaneous alert.
- R7: A rising acknowledge on channel k while esc_req_o[k] is low sets esc_err_o[k]. The flag holds until clr_i. An acknowledge that rises while the request is high sets nothing.
- R8: On entry to the RESET phase, cause_o takes the enabled alerts seen since the last clear and cause_vld_o goes to 1. Both are kept through rst_ni and cleared only by por_ni.
- R9: Alerts that arrive during an escalation do not restart the phases, but they are added to the set that R8 records.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencer |
| por_ni | input | 1 | Active-low power-on reset of the cause record |
| alert_req_i | input | N_ALERTS | Alert requests from sources |
| alert_test_i | input | N_ALERTS | Software alert injection strobes |
| alert_en_i | input | N_ALERTS | Per-alert enable mask |
| clr_i | input | 1 | Software escalation clear |
| phase_cyc_i | input | 4*CNT_W | Per-phase length in cycles, phase k in slice k |
| esc_ack_i | input | 4 | Acknowledge from each escalation receiver |
| esc_req_o | output | 4 | Escalation requests: NMI, wipe, scrap, reset |
| esc_err_o | output | 4 | Sticky handshake protocol error per channel |
| cause_o | output | N_ALERTS | Alerts recorded at RESET entry |
| cause_vld_o | output | 1 | Cause record holds a capture |

## Verification
The bench builds the block with N_ALERTS = 4 and CNT_W = 8. Phase lengths are driven between 0 and 5, which keeps a full four-phase run within a few cycles, so every phase boundary and the zero-length case can be compared cycle by cycle. Four alerts are enough to mix a disabled source, a test-strobe source and alerts that arrive mid-escalation into the same cause word. This shows that the record accumulates alerts rather than keeping only the first one.

// File: rtl/esc_pkg.sv
package esc_pkg;
    localparam int unsigned NPH = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NMI,
        ST_WIPE,
        ST_SCRAP,
        ST_RESET,
        ST_DONE
    } esc_state_e;
endpackage

// File: rtl/esc_alert_gather.sv
module esc_alert_gather #(
    parameter int unsigned N_ALERTS = 4
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [N_ALERTS-1:0] alert_req_i,
    input  logic [N_ALERTS-1:0] alert_test_i,
    input  logic [N_ALERTS-1:0] alert_en_i,
    input  logic                clr_i,
    output logic                trig_o,
    output logic [N_ALERTS-1:0] seen_o
);
    logic [N_ALERTS-1:0] hit;
    logic [N_ALERTS-1:0] seen_q;

    // test strobe is merged before the mask: identical path to a real source
    assign hit    = (alert_req_i | alert_test_i) & alert_en_i;
    assign trig_o = |hit;
    assign seen_o = seen_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seen_q <= '0;
        end else if (clr_i) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_q | hit;
        end
    end
endmodule

// File: rtl/esc_phase_fsm.sv
module esc_phase_fsm
    import esc_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      trig_i,
    input  logic                      clr_i,
    input  logic [NPH-1:0][CNT_W-1:0] phase_cyc_i,
    output logic [NPH-1:0]            esc_req_o,
    output logic                      cap_o
);
    esc_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_sel;
    logic [CNT_W-1:0] len_eff;
    logic             in_phase;
    logic             phase_end;
    logic [NPH-1:0]   req_q;

    always_comb begin
        case (state_q)
            ST_NMI:   len_sel = phase_cyc_i[0];
            ST_WIPE:  len_sel = phase_cyc_i[1];
            ST_SCRAP: len_sel = phase_cyc_i[2];
            ST_RESET: len_sel = phase_cyc_i[3];
            default:  len_sel = CNT_W'(1);
        endcase
    end

    assign len_eff   = (len_sel == '0) ? CNT_W'(1) : len_sel;
    assign in_phase  = (state_q == ST_NMI) || (state_q == ST_WIPE) ||
                       (state_q == ST_SCRAP) || (state_q == ST_RESET);
    assign phase_end = in_phase && (cnt_q >= (len_eff - CNT_W'(1)));

    // next state
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (trig_i)    state_d = ST_NMI;
                ST_NMI:   if (phase_end) state_d = ST_WIPE;
                ST_WIPE:  if (phase_end) state_d = ST_SCRAP;
                ST_SCRAP: if (phase_end) state_d = ST_RESET;
                ST_RESET: if (phase_end) state_d = ST_DONE;
                ST_DONE:  state_d = ST_DONE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // state register and phase counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (in_phase) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // registered outputs, decoded from the next state so they align with state_q
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            unique case (state_d)
                ST_NMI:   req_q <= 4'b0001;
                ST_WIPE:  req_q <= 4'b0010;
                ST_SCRAP: req_q <= 4'b0100;
                ST_RESET: req_q <= 4'b1000;
                ST_IDLE:  req_q <= 4'b0000;
                ST_DONE:  req_q <= 4'b0000;
                default:  req_q <= 4'b0000;
            endcase
        end
    end

    assign esc_req_o = req_q;
    assign cap_o     = (state_q == ST_SCRAP) && (state_d == ST_RESET);
endmodule

// File: rtl/esc_hs_mon.sv
module esc_hs_mon #(
    parameter int unsigned N_CH = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            clr_i,
    input  logic [N_CH-1:0] req_i,
    input  logic [N_CH-1:0] ack_i,
    output logic [N_CH-1:0] err_o
);
    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        logic ack_q;
        logic err_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                ack_q <= 1'b0;
                err_q <= 1'b0;
            end else begin
                ack_q <= ack_i[k];
                if (clr_i) begin
                    err_q <= 1'b0;
                end else if (ack_i[k] && !ack_q && !req_i[k]) begin
                    err_q <= 1'b1;
                end
            end
        end
        assign err_o[k] = err_q;
    end
endmodule

// File: rtl/esc_cause_rec.sv
module esc_cause_rec #(
    parameter int unsigned N_ALERTS = 4
) (
    input  logic                clk_i,
    input  logic                por_ni,
    input  logic                cap_i,
    input  logic [N_ALERTS-1:0] seen_i,
    output logic [N_ALERTS-1:0] cause_o,
    output logic                vld_o
);
    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            cause_o <= '0;
            vld_o   <= 1'b0;
        end else if (cap_i) begin
            cause_o <= seen_i;
            vld_o   <= 1'b1;
        end
    end
endmodule

// File: rtl/esc_phase_seq.sv
module esc_phase_seq
    import esc_pkg::*;
#(
    parameter int unsigned N_ALERTS = 4,
    parameter int unsigned CNT_W    = 16
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      por_ni,
    input  logic [N_ALERTS-1:0]       alert_req_i,
    input  logic [N_ALERTS-1:0]       alert_test_i,
    input  logic [N_ALERTS-1:0]       alert_en_i,
    input  logic                      clr_i,
    input  logic [NPH-1:0][CNT_W-1:0] phase_cyc_i,
    input  logic [NPH-1:0]            esc_ack_i,
    output logic [NPH-1:0]            esc_req_o,
    output logic [NPH-1:0]            esc_err_o,
    output logic [N_ALERTS-1:0]       cause_o,
    output logic                      cause_vld_o
);
    logic                trig;
    logic [N_ALERTS-1:0] seen;
    logic                cap;

    esc_alert_gather #(.N_ALERTS(N_ALERTS)) u_gather (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .alert_req_i  (alert_req_i),
        .alert_test_i (alert_test_i),
        .alert_en_i   (alert_en_i),
        .clr_i        (clr_i),
        .trig_o       (trig),
        .seen_o       (seen)
    );

    esc_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .trig_i      (trig),
        .clr_i       (clr_i),
        .phase_cyc_i (phase_cyc_i),
        .esc_req_o   (esc_req_o),
        .cap_o       (cap)
    );

    esc_hs_mon #(.N_CH(NPH)) u_hs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .req_i  (esc_req_o),
        .ack_i  (esc_ack_i),
        .err_o  (esc_err_o)
    );

    esc_cause_rec #(.N_ALERTS(N_ALERTS)) u_cause (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .cap_i   (cap),
        .seen_i  (seen),
        .cause_o (cause_o),
        .vld_o   (cause_vld_o)
    );
endmodule

// File: rtl/esc_phase_seq_chk.sv
module esc_phase_seq_chk #(
    parameter int unsigned N_ALERTS = 4
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                por_ni,
    input logic [N_ALERTS-1:0] alert_req_i,
    input logic [N_ALERTS-1:0] alert_test_i,
    input logic [N_ALERTS-1:0] alert_en_i,
    input logic                clr_i,
    input logic [3:0]          esc_req_o,
    input logic [3:0]          esc_err_o,
    input logic [N_ALERTS-1:0] cause_o,
    input logic                cause_vld_o
);
    a_r4_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(esc_req_o));

    a_r4_nmi_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (esc_req_o[0] && !clr_i) |=> (esc_req_o[0] || esc_req_o[1]));

    a_r4_wipe_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (esc_req_o[1] && !clr_i) |=> (esc_req_o[1] || esc_req_o[2]));

    a_r4_scrap_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (esc_req_o[2] && !clr_i) |=> (esc_req_o[2] || esc_req_o[3]));

    a_r5_reset_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (esc_req_o[3] && !clr_i) |=> (esc_req_o[3] || esc_req_o == 4'b0000));

    a_r2_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(esc_req_o[0]) |-> $past(|((alert_req_i | alert_test_i) & alert_en_i)));

    a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (esc_req_o == 4'b0000));

    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_i |=> ((esc_err_o & $past(esc_err_o)) == $past(esc_err_o)));

    a_r8_cause_only_at_entry: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
        !$stable(cause_o) |-> $rose(esc_req_o[3]));

    a_r8_vld_at_entry: assert property (@(posedge clk_i) disable iff (!rst_ni || !por_ni)
        $rose(esc_req_o[3]) |-> cause_vld_o);
endmodule

bind esc_phase_seq esc_phase_seq_chk #(.N_ALERTS(N_ALERTS)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .por_ni       (por_ni),
    .alert_req_i  (alert_req_i),
    .alert_test_i (alert_test_i),
    .alert_en_i   (alert_en_i),
    .clr_i        (clr_i),
    .esc_req_o    (esc_req_o),
    .esc_err_o    (esc_err_o),
    .cause_o      (cause_o),
    .cause_vld_o  (cause_vld_o)
);

// File: tb/tb_esc_phase_seq.sv
`timescale 1ns/100ps
module tb_esc_phase_seq;
    localparam int NA = 4;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_n = 1'b0;
    logic [NA-1:0] areq = '0, atest = '0, aen = '0;
    logic clr = 1'b0;
    logic [3:0][CW-1:0] cyc = '0;
    logic [3:0] ack = '0;
    logic [3:0] esc_req, esc_err;
    logic [NA-1:0] cause;
    logic cause_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [3:0] exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    esc_phase_seq #(.N_ALERTS(NA), .CNT_W(CW)) dut (
        .clk_i(clk), .rst_ni(rst_n), .por_ni(por_n),
        .alert_req_i(areq), .alert_test_i(atest), .alert_en_i(aen),
        .clr_i(clr), .phase_cyc_i(cyc), .esc_ack_i(ack),
        .esc_req_o(esc_req), .esc_err_o(esc_err),
        .cause_o(cause), .cause_vld_o(cause_vld)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected request vectors, one per cycle, for a full run
    task automatic push_run(input string tag);
        for (int k = 0; k < 4; k++) begin
            int n = (cyc[k] == 0) ? 1 : int'(cyc[k]);
            for (int i = 0; i < n; i++) begin
                exp_q.push_back(4'(1 << k));
                tag_q.push_back(tag);
            end
        end
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(4'b0000);
            tag_q.push_back("R5");
        end
    endtask

    task automatic push_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(4'b0000);
            tag_q.push_back(tag);
        end
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
    endtask

    // monitor: compares outputs after each edge against the scoreboard
    always begin
        @(posedge clk);
        #1;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(esc_req == e, t, "esc_req", esc_req, e);
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        check(esc_req == 0, "R1", "esc_req after reset", esc_req, 0);
        check(esc_err == 0, "R1", "esc_err after reset", esc_err, 0);
        check(cause_vld == 0, "R8", "cause_vld after por", cause_vld, 0);

        // R2: disabled alert is ignored
        aen = 4'b1011;
        cyc[0] = 8'd3; cyc[1] = 8'd1; cyc[2] = 8'd4; cyc[3] = 8'd2;
        areq[2] = 1'b1;
        push_idle(4, "R2");
        @(negedge clk); areq = '0;
        drain();

        // R2/R4 run from alert 0, with alert 1 arriving mid-run (R9)
        @(negedge clk);
        areq[0] = 1'b1;
        push_run("R4/R9");
        @(negedge clk); areq = '0;
        repeat (3) @(negedge clk);
        areq[1] = 1'b1;
        @(negedge clk); areq = '0;
        drain();
        check(cause == 4'b0011, "R8", "cause after run", cause, 4'b0011);
        check(cause_vld == 1, "R8", "cause_vld after run", cause_vld, 1);

        // R5: alerts in DONE ignored
        areq[0] = 1'b1;
        push_idle(3, "R5");
        @(negedge clk); areq = '0;
        drain();

        // R8: record survives rst_ni
        rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(cause == 4'b0011, "R8", "cause across rst", cause, 4'b0011);
        check(cause_vld == 1, "R8", "cause_vld across rst", cause_vld, 1);
        check(esc_req == 0, "R1", "esc_req after rst", esc_req, 0);

        // R3: test strobe, zero-length first phase (R4)
        pulse_clr();
        cyc[0] = 8'd0; cyc[1] = 8'd2; cyc[2] = 8'd1; cyc[3] = 8'd1;
        atest[3] = 1'b1;
        push_run("R3/R4");
        @(negedge clk); atest = '0;
        drain();
        check(cause == 4'b1000, "R3", "cause from test strobe", cause, 4'b1000);

        // R6: clear mid-escalation
        pulse_clr();
        cyc = {8'd5, 8'd5, 8'd5, 8'd5};
        areq[1] = 1'b1;
        @(negedge clk); areq = '0;
        check(esc_req == 4'b0001, "R2", "esc_req after alert", esc_req, 4'b0001);
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check(esc_req == 0, "R6", "esc_req after clear", esc_req, 0);
        repeat (2) @(negedge clk);
        check(esc_req == 0, "R6", "esc_req stays idle", esc_req, 0);

        // R6: clear beats simultaneous alert
        clr = 1'b1; areq[0] = 1'b1;
        @(negedge clk); clr = 1'b0; areq = '0;
        check(esc_req == 0, "R6", "clear priority", esc_req, 0);
        @(negedge clk);
        check(esc_req == 0, "R6", "clear priority hold", esc_req, 0);

        // R7: ack rising without request
        ack[2] = 1'b1;
        @(negedge clk); ack = '0;
        check(esc_err == 4'b0100, "R7", "err on stray ack", esc_err, 4'b0100);
        areq[0] = 1'b1;
        @(negedge clk); areq = '0; ack[0] = 1'b1;
        @(negedge clk);
        check(esc_err == 4'b0100, "R7", "no err on valid ack", esc_err, 4'b0100);
        ack = '0;
        @(negedge clk);
        check(esc_err == 4'b0100, "R7", "err sticky", esc_err, 4'b0100);
        pulse_clr();
        check(esc_err == 0, "R7", "err cleared", esc_err, 0);

        // R8: power-on reset clears the record
        rst_n = 1'b0; por_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);
        check(cause_vld == 0, "R8", "cause_vld after por", cause_vld, 0);
        check(cause == 0, "R8", "cause after por", cause, 0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule